// File: doc/BRIEF.md
# Dual Converter Start Scheduler

This block sits between one trigger source and two analog-to-digital converter cores: a lead core and a follower core. It accepts a gated trigger and turns it into start strobes for both cores. The pattern depends on the selected mode. The two simultaneous modes start both cores together, one for the injected group and one for the regular group. The two interleaved modes start the follower at once and the lead core after a fixed number of clock cycles.

The block counts the completion strobes that come back from the cores. It raises a one-cycle end pulse when a sequence finishes, and it packs the returned samples into one 32-bit result word. It also keeps sticky flags for several events:
- a trigger that arrives while a sequence is running;
- a sampling time too long for the interleave offset;
- a continuous request made in the slow interleaved mode;
- both cores set to the same channel in a simultaneous mode.

Mode codes on `modeSel`: 0 = injected simultaneous, 1 = regular simultaneous, 2 = fast interleaved, 3 = slow interleaved. The cycle in which a trigger is sampled high on a rising clock edge and accepted is called the accept edge. Cycle A1 is the clock cycle that follows it, and An is the n-th cycle after it.

Top module: `dual_adc_sched`

## Requirements
- R1: Out of reset the block drives `mstStart`, `slvStart`, `eocPulse`, `jeocPulse`, `busy` and every flag low, and `resultWord` is zero.
- R2: A trigger counts only when `trigIn` and `trigEn` are both high. With `trigEn` low, no start is issued and `busy` stays low.
- R3: In modes 0 and 1, an accepted trigger drives `mstStart` and `slvStart` high together in A1, for one cycle.
- R4: In modes 0 and 1, the group length is set when the trigger is accepted. Mode 1 uses `lenCode`+1 channels (1 to 16). Mode 0 uses `lenCode[1:0]`+1 channels (1 to 4). The end pulse is high for exactly the one cycle after both cores have returned that many completion strobes: `eocPulse` in mode 1, `jeocPulse` in mode 0. It is never high earlier.
- R5: In mode 1, each pair of samples (the n-th from the lead core and the n-th from the follower, in either order) is written as {follower[15:0], lead[15:0]}. The write happens in the cycle after the later of the two strobes. Mode 0 never changes `resultWord`.
- R6: In mode 2, `slvStart` is high in A1 and `mstStart` is high in A8, seven cycles later.
- R7: In mode 2 with `contReq` high, each lead-core completion issues a new `slvStart` in the next cycle, followed by `mstStart` seven cycles after it. The first lead-core completion seen with `contReq` low ends the sequence.
- R8: In mode 3, `slvStart` is high in A1 and again in A29, and `mstStart` is high in A15. `busy` falls in the cycle after A29, or in the cycle after the lead core's completion if that comes later.
- R9: In mode 3, a high `contReq` is ignored: no start is issued beyond the pattern of R8, and the sticky `contErr` is set.
- R10: A trigger is rejected, with no start issued and `sampleErr` set, when `sampleTime` >= 7 in mode 2 or `sampleTime` >= 14 in mode 3. A `sampleTime` of 6 in mode 2 is accepted.
- R11: In modes 2 and 3, during a sequence, a lead-core completion writes `mstData` into bits [15:0] and raises `eocPulse` in the next cycle. A follower completion writes `slvData` into bits [31:16].
- R12: A trigger that arrives while `busy` is high sets the sticky `ovrFlag`, issues no start, and leaves the running sequence unchanged.
- R13: The mode is captured on the accept edge. A change on `modeSel` during a sequence does not alter that sequence.
- R14: In modes 0 and 1, a trigger with `mstChan` equal to `slvChan` is rejected, and the sticky `clashErr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigIn | input | 1 | Trigger from the lead converter's source |
| trigEn | input | 1 | Lead converter's trigger enable |
| modeSel | input | 2 | Requested scheduling mode |
| contReq | input | 1 | Continuous conversion request |
| sampleTime | input | 4 | Configured sampling time in cycles |
| lenCode | input | 4 | Group length minus one |
| mstChan | input | 4 | Channel selected on the lead core |
| slvChan | input | 4 | Channel selected on the follower core |
| mstDone | input | 1 | Lead core conversion-complete strobe |
| slvDone | input | 1 | Follower core conversion-complete strobe |
| mstData | input | 16 | Lead core sample |
| slvData | input | 16 | Follower core sample |
| mstStart | output | 1 | Start strobe to the lead core |
| slvStart | output | 1 | Start strobe to the follower core |
| eocPulse | output | 1 | Regular end-of-conversion pulse |
| jeocPulse | output | 1 | Injected end-of-conversion pulse |
| resultWord | output | 32 | Packed result {follower, lead} |
| busy | output | 1 | Sequence in progress |
| ovrFlag | output | 1 | Sticky: trigger during a sequence |
| sampleErr | output | 1 | Sticky: sampling time too long |
| contErr | output | 1 | Sticky: continuous request in slow mode |
| clashErr | output | 1 | Sticky: same channel on both cores |

## Verification
The simultaneous modes are run from a table of vectors:
- single-channel and full 16-channel regular groups, which separate the counting limit from off-by-one errors;
- an injected code whose upper bits are set, which shows that only the low two bits set the injected length;
- vectors with the follower finishing first, which show that pairing does not depend on which core reports first.

The interleaved modes are observed cycle by cycle, so a start that is one cycle early or late shows up as a wrong index. The continuous runs tell a re-arming fast sequence apart from a slow sequence that must end after its single restart. Directed triggers cover each rejection path (gating, sampling limit at 6 against 7, channel clash, overrun) and a mid-sequence mode change.

// File: rtl/dadc_pkg.sv
package dadc_pkg;

  typedef enum logic [1:0] {
    M_INJ_SIM = 2'd0,
    M_REG_SIM = 2'd1,
    M_FAST_IL = 2'd2,
    M_SLOW_IL = 2'd3
  } mode_e;

  // Strobes from the scheduler to the result packer
  typedef struct packed {
    logic pairEn;   // regular simultaneous: pair samples
    logic splitEn;  // interleaved: write halves independently
    logic clrPair;  // new sequence: drop half-filled pair
  } strobe_t;

endpackage

// File: rtl/dadc_ctrl.sv
module dadc_ctrl
  import dadc_pkg::*;
#(
  parameter int STW          = 4,
  parameter int CHW          = 4,
  parameter int LENW         = 4,
  parameter int FAST_GAP     = 7,
  parameter int SLOW_GAP     = 14,
  parameter int SLOW_RESTART = 28
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigIn,
  input  logic            trigEn,
  input  logic [1:0]      modeSel,
  input  logic            contReq,
  input  logic [STW-1:0]  sampleTime,
  input  logic [LENW-1:0] lenCode,
  input  logic [CHW-1:0]  mstChan,
  input  logic [CHW-1:0]  slvChan,
  input  logic            mstDone,
  input  logic            slvDone,
  output logic            mstStart,
  output logic            slvStart,
  output logic            eocPulse,
  output logic            jeocPulse,
  output logic            busy,
  output logic            ovrFlag,
  output logic            sampleErr,
  output logic            contErr,
  output logic            clashErr,
  output strobe_t         strobes
);

  localparam int CNTW = $clog2(SLOW_RESTART + 1);
  localparam int GRPW = LENW + 1;
  localparam logic [CNTW-1:0] FAST_C    = CNTW'(FAST_GAP);
  localparam logic [CNTW-1:0] FAST_PRE  = CNTW'(FAST_GAP - 1);
  localparam logic [CNTW-1:0] SLOW_PRE  = CNTW'(SLOW_GAP - 1);
  localparam logic [CNTW-1:0] RST_C     = CNTW'(SLOW_RESTART);
  localparam logic [CNTW-1:0] RST_PRE   = CNTW'(SLOW_RESTART - 1);
  localparam logic [STW:0]    FAST_LIM  = (STW+1)'(FAST_GAP);
  localparam logic [STW:0]    SLOW_LIM  = (STW+1)'(SLOW_GAP);

  mode_e           curMode, reqMode;
  logic [CNTW-1:0] cnt, cntLim;
  logic [GRPW-1:0] mCnt, sCnt, lenTgt, nextM, nextS;
  logic            contLatch, mstSeen;
  logic            trigHit, reqSim, curSim, curFast, curSlow;
  logic            sampleBad, chanClash, accept, simDone, fastEnd, slowEnd;

  assign reqMode   = mode_e'(modeSel);
  assign trigHit   = trigIn & trigEn;
  assign reqSim    = (reqMode == M_INJ_SIM) || (reqMode == M_REG_SIM);
  assign curSim    = (curMode == M_INJ_SIM) || (curMode == M_REG_SIM);
  assign curFast   = (curMode == M_FAST_IL);
  assign curSlow   = (curMode == M_SLOW_IL);
  assign sampleBad = ((reqMode == M_FAST_IL) && ({1'b0, sampleTime} >= FAST_LIM)) ||
                     ((reqMode == M_SLOW_IL) && ({1'b0, sampleTime} >= SLOW_LIM));
  assign chanClash = reqSim && (mstChan == slvChan);
  assign accept    = trigHit && !busy && !sampleBad && !chanClash;
  assign nextM     = mCnt + GRPW'(mstDone);
  assign nextS     = sCnt + GRPW'(slvDone);
  assign simDone   = busy && curSim && (nextM >= lenTgt) && (nextS >= lenTgt);
  assign fastEnd   = busy && curFast && mstDone;
  assign slowEnd   = busy && curSlow && (cnt == RST_C) && (mstSeen || mstDone);
  assign cntLim    = curFast ? FAST_C : RST_C;

  assign strobes.pairEn  = busy && (curMode == M_REG_SIM);
  assign strobes.splitEn = busy && !curSim;
  assign strobes.clrPair = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode   <= M_INJ_SIM;
      cnt       <= '0;
      mCnt      <= '0;
      sCnt      <= '0;
      lenTgt    <= '0;
      contLatch <= 1'b0;
      mstSeen   <= 1'b0;
      busy      <= 1'b0;
      mstStart  <= 1'b0;
      slvStart  <= 1'b0;
      eocPulse  <= 1'b0;
      jeocPulse <= 1'b0;
      ovrFlag   <= 1'b0;
      sampleErr <= 1'b0;
      contErr   <= 1'b0;
      clashErr  <= 1'b0;
    end else begin
      mstStart  <= 1'b0;
      slvStart  <= 1'b0;
      eocPulse  <= 1'b0;
      jeocPulse <= 1'b0;
      if (trigHit && busy)               ovrFlag   <= 1'b1;
      if (trigHit && !busy && sampleBad) sampleErr <= 1'b1;
      if (trigHit && !busy && chanClash) clashErr  <= 1'b1;
      if (accept) begin
        busy      <= 1'b1;
        curMode   <= reqMode;
        cnt       <= '0;
        mCnt      <= '0;
        sCnt      <= '0;
        mstSeen   <= 1'b0;
        contLatch <= contReq && (reqMode == M_FAST_IL);
        if (contReq && (reqMode == M_SLOW_IL)) contErr <= 1'b1;
        lenTgt    <= (reqMode == M_INJ_SIM) ? GRPW'(lenCode[1:0]) + GRPW'(1)
                                            : GRPW'(lenCode) + GRPW'(1);
        slvStart  <= 1'b1;
        mstStart  <= reqSim;
      end else if (busy) begin
        if (curSim) begin
          mCnt <= nextM;
          sCnt <= nextS;
          if (simDone) begin
            busy <= 1'b0;
            if (curMode == M_REG_SIM) eocPulse  <= 1'b1;
            else                      jeocPulse <= 1'b1;
          end
        end else begin
          if (cnt < cntLim) cnt <= cnt + CNTW'(1);
          if (curFast && cnt == FAST_PRE) mstStart <= 1'b1;
          if (curSlow && cnt == SLOW_PRE) mstStart <= 1'b1;
          if (curSlow && cnt == RST_PRE)  slvStart <= 1'b1;
          if (mstDone) begin
            eocPulse <= 1'b1;
            mstSeen  <= 1'b1;
          end
          if (fastEnd) begin
            if (contLatch && contReq) begin
              slvStart <= 1'b1;
              cnt      <= '0;
            end else begin
              busy <= 1'b0;
            end
          end
          if (slowEnd) busy <= 1'b0;
        end
      end
    end
  end

  // Independent cycle counter since the last follower start, for checking only
  logic [CNTW:0] sinceSlv;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceSlv <= '1;
    else if (slvStart)         sinceSlv <= (CNTW+1)'(1);
    else if (sinceSlv != '1)   sinceSlv <= sinceSlv + (CNTW+1)'(1);
  end

  // R3
  sim_pair_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstStart && curSim) |-> slvStart);

  // R6
  fast_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstStart && curFast) |-> (sinceSlv == (CNTW+1)'(FAST_GAP)));

  // R8
  slow_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mstStart && curSlow) |-> (sinceSlv == (CNTW+1)'(SLOW_GAP)));

  // R12
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigIn && trigEn) |=> ovrFlag);

  // R10
  sample_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigIn && trigEn && sampleBad) |=> (!slvStart && sampleErr));

  // R4
  end_in_sequence_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eocPulse || jeocPulse) |-> $past(busy));

endmodule

// File: rtl/dadc_data.sv
module dadc_data
  import dadc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic          mstDone,
  input  logic          slvDone,
  input  logic [DW-1:0] mstData,
  input  logic [DW-1:0] slvData,
  output logic [2*DW-1:0] resultWord
);

  logic [DW-1:0] mHold, sHold, mCur, sCur;
  logic          mValid, sValid, haveM, haveS;

  assign haveM = mValid | mstDone;
  assign haveS = sValid | slvDone;
  assign mCur  = mstDone ? mstData : mHold;
  assign sCur  = slvDone ? slvData : sHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHold      <= '0;
      sHold      <= '0;
      mValid     <= 1'b0;
      sValid     <= 1'b0;
      resultWord <= '0;
    end else if (strobes.clrPair) begin
      mValid <= 1'b0;
      sValid <= 1'b0;
    end else if (strobes.pairEn) begin
      if (haveM && haveS) begin
        resultWord <= {sCur, mCur};
        mValid     <= 1'b0;
        sValid     <= 1'b0;
      end else begin
        if (mstDone) begin
          mHold  <= mstData;
          mValid <= 1'b1;
        end
        if (slvDone) begin
          sHold  <= slvData;
          sValid <= 1'b1;
        end
      end
    end else if (strobes.splitEn) begin
      if (mstDone) resultWord[DW-1:0]    <= mstData;
      if (slvDone) resultWord[2*DW-1:DW] <= slvData;
    end
  end

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.pairEn && !strobes.splitEn) |=> $stable(resultWord));

  // R5
  pair_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pairEn && !strobes.clrPair && mstDone && slvDone && !mValid && !sValid)
      |=> (resultWord == {$past(slvData), $past(mstData)}));

  // R11
  split_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.splitEn && !strobes.clrPair && mstDone) |=> (resultWord[DW-1:0] == $past(mstData)));

endmodule

// File: rtl/dual_adc_sched.sv
module dual_adc_sched
  import dadc_pkg::*;
#(
  parameter int DW           = 16,
  parameter int STW          = 4,
  parameter int CHW          = 4,
  parameter int LENW         = 4,
  parameter int FAST_GAP     = 7,
  parameter int SLOW_GAP     = 14,
  parameter int SLOW_RESTART = 28
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigIn,
  input  logic            trigEn,
  input  logic [1:0]      modeSel,
  input  logic            contReq,
  input  logic [STW-1:0]  sampleTime,
  input  logic [LENW-1:0] lenCode,
  input  logic [CHW-1:0]  mstChan,
  input  logic [CHW-1:0]  slvChan,
  input  logic            mstDone,
  input  logic            slvDone,
  input  logic [DW-1:0]   mstData,
  input  logic [DW-1:0]   slvData,
  output logic            mstStart,
  output logic            slvStart,
  output logic            eocPulse,
  output logic            jeocPulse,
  output logic [2*DW-1:0] resultWord,
  output logic            busy,
  output logic            ovrFlag,
  output logic            sampleErr,
  output logic            contErr,
  output logic            clashErr
);

  strobe_t strobes;

  dadc_ctrl #(
    .STW(STW), .CHW(CHW), .LENW(LENW),
    .FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP), .SLOW_RESTART(SLOW_RESTART)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .trigEn(trigEn),
    .modeSel(modeSel), .contReq(contReq), .sampleTime(sampleTime),
    .lenCode(lenCode), .mstChan(mstChan), .slvChan(slvChan),
    .mstDone(mstDone), .slvDone(slvDone),
    .mstStart(mstStart), .slvStart(slvStart),
    .eocPulse(eocPulse), .jeocPulse(jeocPulse), .busy(busy),
    .ovrFlag(ovrFlag), .sampleErr(sampleErr), .contErr(contErr),
    .clashErr(clashErr), .strobes(strobes)
  );

  dadc_data #(.DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .mstDone(mstDone), .slvDone(slvDone),
    .mstData(mstData), .slvData(slvData),
    .resultWord(resultWord)
  );

endmodule

// File: tb/sim_dual_adc_sched.sv
module sim_dual_adc_sched;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0, trigEn = 1'b1, contReq = 1'b0;
  logic [1:0]  modeSel = 2'd1;
  logic [3:0]  sampleTime = 4'd3, lenCode = 4'd0, mstChan = 4'd1, slvChan = 4'd2;
  logic        mstDone = 1'b0, slvDone = 1'b0;
  logic [15:0] mstData = '0, slvData = '0;
  logic        mstStart, slvStart, eocPulse, jeocPulse, busy;
  logic        ovrFlag, sampleErr, contErr, clashErr;
  logic [31:0] resultWord;

  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  dual_adc_sched u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .trigEn(trigEn), .modeSel(modeSel),
    .contReq(contReq), .sampleTime(sampleTime), .lenCode(lenCode),
    .mstChan(mstChan), .slvChan(slvChan), .mstDone(mstDone), .slvDone(slvDone),
    .mstData(mstData), .slvData(slvData), .mstStart(mstStart), .slvStart(slvStart),
    .eocPulse(eocPulse), .jeocPulse(jeocPulse), .resultWord(resultWord), .busy(busy),
    .ovrFlag(ovrFlag), .sampleErr(sampleErr), .contErr(contErr), .clashErr(clashErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseTrig();
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic mPulse(input logic [15:0] d);
    mstData = d; mstDone = 1'b1;
    @(negedge clk);
    mstDone = 1'b0;
  endtask

  task automatic sPulse(input logic [15:0] d);
    slvData = d; slvDone = 1'b1;
    @(negedge clk);
    slvDone = 1'b0;
  endtask

  task automatic observe(input int from, input int upto,
                         output int sF, output int sN, output int mF, output int iF);
    sF = -1; sN = 0; mF = -1; iF = -1;
    for (int i = from; i <= upto; i++) begin
      if (slvStart) begin
        if (sF < 0) sF = i;
        sN++;
      end
      if (mstStart && mF < 0) mF = i;
      if (!busy && iF < 0) iF = i;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  len;
    logic        sFirst;
    logic [15:0] mB;
    logic [15:0] sB;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 4'd0,  1'b0, 16'h1000, 16'h2000},
    '{2'd1, 4'd15, 1'b0, 16'h1100, 16'h2200},
    '{2'd0, 4'd3,  1'b0, 16'h3000, 16'h4000},
    '{2'd0, 4'd13, 1'b1, 16'h5000, 16'h6000},
    '{2'd1, 4'd2,  1'b1, 16'h7000, 16'h8000},
    '{2'd1, 4'd5,  1'b0, 16'hA000, 16'hB000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    int sF, sN, mF, iF, n;
    bit early;
    logic [31:0] expWord;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mstStart, slvStart, eocPulse, jeocPulse, busy} == 5'b0, "R1 strobes", {27'd0, mstStart, slvStart, eocPulse, jeocPulse, busy}, 0);
    chk({ovrFlag, sampleErr, contErr, clashErr} == 4'b0, "R1 flags", {28'd0, ovrFlag, sampleErr, contErr, clashErr}, 0);
    chk(resultWord == 32'd0, "R1 word", resultWord, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4 R5 vector walk over the simultaneous modes
    expWord = 32'd0;
    foreach (VECS[v]) begin
      modeSel = VECS[v].mode; lenCode = VECS[v].len;
      n = (VECS[v].mode == 2'd0) ? int'(VECS[v].len[1:0]) + 1 : int'(VECS[v].len) + 1;
      pulseTrig();
      chk(mstStart && slvStart, "R3 paired start", {30'd0, mstStart, slvStart}, 3);
      early = 1'b0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        if (VECS[v].sFirst) begin
          sPulse(VECS[v].sB + 16'(k));
          mPulse(VECS[v].mB + 16'(k));
        end else begin
          mPulse(VECS[v].mB + 16'(k));
          sPulse(VECS[v].sB + 16'(k));
        end
        if (k < n - 1 && (eocPulse || jeocPulse)) early = 1'b1;
      end
      chk(!early, "R4 no early end", {31'd0, early}, 0);
      if (VECS[v].mode == 2'd1) begin
        expWord = {VECS[v].sB + 16'(n - 1), VECS[v].mB + 16'(n - 1)};
        chk(eocPulse && !jeocPulse, "R4 regular end", {30'd0, eocPulse, jeocPulse}, 2);
      end else begin
        chk(jeocPulse && !eocPulse, "R4 injected end", {30'd0, eocPulse, jeocPulse}, 1);
      end
      chk(resultWord == expWord, "R5 packed word", resultWord, expWord);
      @(negedge clk);
      chk(!eocPulse && !jeocPulse && !busy, "R4 single pulse", {29'd0, eocPulse, jeocPulse, busy}, 0);
    end

    // R2 gated trigger
    trigEn = 1'b0; modeSel = 2'd1; lenCode = 4'd0;
    pulseTrig();
    observe(1, 5, sF, sN, mF, iF);
    chk(sN == 0 && mF < 0 && iF == 1, "R2 gated", sN, 0);
    trigEn = 1'b1;

    // R14 channel clash
    mstChan = 4'd5; slvChan = 4'd5;
    pulseTrig();
    observe(1, 5, sF, sN, mF, iF);
    chk(sN == 0 && clashErr, "R14 clash", {31'd0, clashErr}, 1);
    mstChan = 4'd1; slvChan = 4'd2;

    // R6 R11 fast interleave, sampleTime 6 at the boundary
    modeSel = 2'd2; sampleTime = 4'd6;
    pulseTrig();
    observe(1, 10, sF, sN, mF, iF);
    chk(sF == 1 && sN == 1, "R6 slave start", sF, 1);
    chk(mF == 8, "R6 master offset", mF, 8);
    sPulse(16'hBBBB);
    mPulse(16'hAAAA);
    chk(eocPulse, "R11 eoc on lead", {31'd0, eocPulse}, 1);
    chk(resultWord == 32'hBBBBAAAA, "R11 halves", resultWord, 32'hBBBBAAAA);
    chk(!busy, "R6 end", {31'd0, busy}, 0);

    // R7 fast continuous
    contReq = 1'b1;
    pulseTrig();
    observe(1, 10, sF, sN, mF, iF);
    mPulse(16'h0101);
    observe(1, 10, sF, sN, mF, iF);
    chk(sF == 1 && mF == 8, "R7 re-arm", mF, 8);
    contReq = 1'b0;
    mPulse(16'h0202);
    chk(!busy && !slvStart, "R7 stop", {30'd0, busy, slvStart}, 0);

    // R8 slow interleave
    modeSel = 2'd3; sampleTime = 4'd13;
    pulseTrig();
    observe(1, 18, sF, sN, mF, iF);
    chk(sF == 1 && mF == 15, "R8 master offset", mF, 15);
    mPulse(16'h1234);
    chk(eocPulse && resultWord[15:0] == 16'h1234, "R11 slow low half", resultWord, 32'h1234);
    observe(20, 35, sF, sN, mF, iF);
    chk(sF == 29 && sN == 1, "R8 restart", sF, 29);
    chk(iF == 30, "R8 end", iF, 30);

    // R9 slow with continuous requested
    contReq = 1'b1;
    pulseTrig();
    observe(1, 18, sF, sN, mF, iF);
    mPulse(16'h4321);
    observe(20, 45, sF, sN, mF, iF);
    chk(sF == 29 && sN == 1 && iF == 30, "R9 no re-arm", sN, 1);
    chk(contErr, "R9 flag", {31'd0, contErr}, 1);
    contReq = 1'b0;

    // R10 sampling limit
    chk(!sampleErr, "R10 boundary 6 accepted", {31'd0, sampleErr}, 0);
    modeSel = 2'd2; sampleTime = 4'd7;
    pulseTrig();
    observe(1, 5, sF, sN, mF, iF);
    chk(sN == 0 && iF == 1 && sampleErr, "R10 fast reject", {31'd0, sampleErr}, 1);
    modeSel = 2'd3; sampleTime = 4'd14;
    pulseTrig();
    observe(1, 5, sF, sN, mF, iF);
    chk(sN == 0 && iF == 1, "R10 slow reject", sN, 0);

    // R12 overrun
    modeSel = 2'd1; lenCode = 4'd0; sampleTime = 4'd3;
    chk(!ovrFlag, "R12 clear before", {31'd0, ovrFlag}, 0);
    pulseTrig();
    pulseTrig();
    chk(ovrFlag && !slvStart && busy, "R12 overrun", {29'd0, ovrFlag, slvStart, busy}, 5);
    mPulse(16'h0A0A);
    sPulse(16'h0B0B);
    chk(eocPulse && resultWord == 32'h0B0B0A0A, "R12 sequence intact", resultWord, 32'h0B0B0A0A);

    // R13 mode change mid-sequence
    modeSel = 2'd2;
    pulseTrig();
    observe(1, 3, sF, sN, mF, iF);
    modeSel = 2'd1;
    observe(4, 10, sF, sN, mF, iF);
    chk(mF == 8, "R13 mode held", mF, 8);
    mPulse(16'h0C0C);
    chk(eocPulse && !busy, "R13 end", {30'd0, eocPulse, busy}, 2);

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule